// File: doc/BRIEF.md
# Multi-mode vectored interrupt controller

This block is the interrupt acknowledge unit of an 8-bit core with a 16-bit address space. It keeps the maskable-interrupt enable flag and a saved copy of it, a response-mode register that holds 0, 1 or 2, and an 8-bit table-base register. At each instruction boundary the core signals, the block checks a latched non-maskable request and a level-sensitive maskable request. If one is accepted, the block runs a short sequence. It pushes the return address onto a descending stack through a memory write port and then hands the core a new program counter and stack pointer.

A maskable request is acknowledged with a one-cycle strobe, and the interrupting device places one byte on the data input during that cycle. In mode 0 that byte must be a single-byte restart opcode, and the block derives the handler address from it. In mode 1 the handler address is fixed. In mode 2 the byte is the low half of a pointer into a table of two-byte handler addresses whose high half is the table-base register, so up to 128 devices can each have their own handler. The instruction decoder sets the mode, the table base and the enable state through one-cycle strobes. The strobes are accepted while the block is idle.

Memory read port timing: the read data input is valid in the same cycle as the read address. The core holds its instruction flow while `busy_o` is high.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset the enable flag (`ie_o`) is 0, the mode is 0, the table base is 0x00, and `busy_o`, `ack_o`, `done_o`, `err_o` and both memory enables are 0.
- R2: A rising edge on `nmi_in` is latched and taken at the next `insn_done`, whatever the enable state. It produces `new_pc` = 0x0066 and no `ack_o`. A level held high after one entry does not cause a second entry.
- R3: A non-maskable entry copies the enable flag into a saved flag and then clears the enable flag. A `cmd_retn` strobe copies the saved flag back to the enable flag.
- R4: When the latched non-maskable request and an enabled maskable request are present at the same `insn_done`, the non-maskable request is taken and the maskable one is not acknowledged.
- R5: A maskable request is acknowledged only while the enable flag is 1. `cmd_en` sets the flag and `cmd_dis` clears it.
- R6: After `cmd_en`, the first `insn_done` that follows cannot accept a maskable request. Acceptance becomes possible from the second `insn_done` onward.
- R7: Accepting a maskable request clears the enable flag and asserts `ack_o` for exactly one cycle, during which `dev_data` is sampled.
- R8: In mode 1 the handler address is 0x0038, whatever byte the device supplies.
- R9: In mode 0 a device byte of the form 11nnn111 (bits 7:6 = 11, bits 2:0 = 111) gives the handler address nnn×8, where nnn is bits 5:3.
- R10: In mode 0 any other device byte gives a one-cycle `err_o` pulse, with no stack write and no `done_o`. The enable flag stays cleared.
- R11: In mode 2 the block reads the low byte of the handler address at {table base, device byte with bit 0 forced to 0} and then the high byte at that address plus 1.
- R12: Every entry writes the return PC high byte to SP-1 in one cycle and the low byte to SP-2 in the next. It then pulses `done_o` for one cycle with `new_sp` = SP-2.
- R13: A `cmd_mode_set` strobe with mode value 3 is ignored, and the previous mode stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_in | input | 1 | Non-maskable request, edge sensitive |
| irq_req | input | 1 | Maskable request, level sensitive |
| insn_done | input | 1 | Instruction boundary strobe from the core |
| cmd_en | input | 1 | Enable-interrupts command strobe |
| cmd_dis | input | 1 | Disable-interrupts command strobe |
| cmd_retn | input | 1 | Restore the enable flag from the saved copy |
| cmd_mode_set | input | 1 | Load the response mode |
| cmd_mode | input | 2 | New response mode (0, 1 or 2) |
| cmd_vec_set | input | 1 | Load the table-base register |
| cmd_vec | input | 8 | New table-base value |
| pc_in | input | 16 | Return address to push |
| sp_in | input | 16 | Current stack pointer |
| dev_data | input | 8 | Byte from the interrupting device |
| ack_o | output | 1 | Maskable acknowledge, one cycle |
| mem_rd_en | output | 1 | Table read enable |
| mem_rd_addr | output | 16 | Table read address |
| mem_rd_data | input | 8 | Table read data, same cycle |
| mem_wr_en | output | 1 | Stack write enable |
| mem_wr_addr | output | 16 | Stack write address |
| mem_wr_data | output | 8 | Stack write data |
| done_o | output | 1 | Entry complete, new PC and SP valid |
| new_pc | output | 16 | Handler address |
| new_sp | output | 16 | Stack pointer after the push |
| err_o | output | 1 | Invalid mode-0 byte |
| busy_o | output | 1 | Entry sequence in progress |
| ie_o | output | 1 | Current enable flag |

## Verification
The main function is exercised with one device byte per mode. Mode 0 gets three restart bytes (lowest, middle and highest vector) and a byte that is not a restart, which checks the decode and the error path. Mode 1 gets a byte that would be a valid restart, which shows that the fixed address ignores the byte. Mode 2 gets an odd device byte, which separates a correct bit-0 clear and little-endian assembly from a swapped or unmasked pointer. Non-maskable entries are run with the flag set, with a simultaneous maskable request, and with the input held high, which separates edge latching, priority and the save/restore of the flag.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int BW = 8;
  localparam int AW = 2 * BW;

  typedef enum logic [2:0] {
    S_IDLE, S_ACK, S_RD_LO, S_RD_HI, S_PUSH_H, S_PUSH_L, S_FIN
  } seq_state_t;

  typedef enum logic [1:0] {
    M_DEV = 2'd0, M_FIX = 2'd1, M_TBL = 2'd2
  } irq_mode_t;

  // single-byte restart opcode: 11 nnn 111
  function automatic logic rst_ok(input logic [BW-1:0] op);
    return (op[7:6] == 2'b11) && (op[2:0] == 3'b111);
  endfunction

  function automatic logic [AW-1:0] rst_target(input logic [BW-1:0] op);
    return {{(AW-6){1'b0}}, op[5:3], 3'b000};
  endfunction

  // table pointer: base byte above, device byte with bit 0 chosen by odd
  function automatic logic [AW-1:0] table_ptr(input logic [BW-1:0] base,
                                               input logic [BW-1:0] lo,
                                               input logic odd);
    return {base, lo[BW-1:1], odd};
  endfunction

  function automatic logic [AW-1:0] stack_slot(input logic [AW-1:0] sp,
                                               input logic [1:0] depth);
    return sp - {{(AW-2){1'b0}}, depth};
  endfunction
endpackage

// File: rtl/irqv_nmi_edge.sv
module irqv_nmi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic take,
  output logic pend
);
  logic nmi_q;
  logic rise;

  assign rise = nmi_in & ~nmi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      nmi_q <= nmi_in;
      if (rise)      pend <= 1'b1;
      else if (take) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/irqv_flags.sv
module irqv_flags
  import irqv_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_ok,
  input  logic          cmd_en,
  input  logic          cmd_dis,
  input  logic          cmd_retn,
  input  logic          cmd_mode_set,
  input  logic [1:0]    cmd_mode,
  input  logic          cmd_vec_set,
  input  logic [BW-1:0] cmd_vec,
  input  logic          insn_done,
  input  logic          take_nmi,
  input  logic          take_irq,
  output logic          ie1,
  output logic          ie2,
  output logic          ei_block,
  output irq_mode_t     mode,
  output logic [BW-1:0] ivec
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie1      <= 1'b0;
      ie2      <= 1'b0;
      ei_block <= 1'b0;
      mode     <= M_DEV;
      ivec     <= '0;
    end else begin
      if (cmd_ok && cmd_en)        ei_block <= 1'b1;
      else if (insn_done)          ei_block <= 1'b0;

      if (take_nmi) begin
        ie2 <= ie1;
        ie1 <= 1'b0;
      end else if (take_irq) begin
        ie1 <= 1'b0;
        ie2 <= 1'b0;
      end else if (cmd_ok) begin
        if (cmd_en) begin
          ie1 <= 1'b1;
          ie2 <= 1'b1;
        end else if (cmd_dis) begin
          ie1 <= 1'b0;
          ie2 <= 1'b0;
        end else if (cmd_retn) begin
          ie1 <= ie2;
        end
      end

      if (cmd_ok && cmd_mode_set && cmd_mode != 2'd3)
        mode <= irq_mode_t'(cmd_mode);
      if (cmd_ok && cmd_vec_set)
        ivec <= cmd_vec;
    end
  end
endmodule

// File: rtl/irqv_seq.sv
module irqv_seq
  import irqv_pkg::*;
#(
  parameter logic [15:0] NMI_VEC = 16'h0066,
  parameter logic [15:0] FIX_VEC = 16'h0038
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          insn_done,
  input  logic          nmi_pend,
  input  logic          irq_req,
  input  logic          ie1,
  input  logic          ei_block,
  input  logic          cmd_en,
  input  irq_mode_t     mode,
  input  logic [BW-1:0] ivec,
  input  logic [BW-1:0] dev_data,
  input  logic [AW-1:0] pc_in,
  input  logic [AW-1:0] sp_in,
  input  logic [BW-1:0] mem_rd_data,
  output logic          take_nmi,
  output logic          take_irq,
  output logic          is_idle,
  output logic          push_hi,
  output logic          push_lo,
  output logic          entry_nmi,
  output logic          ack_o,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_wr_addr,
  output logic [BW-1:0] mem_wr_data,
  output logic          done_o,
  output logic [AW-1:0] new_pc,
  output logic [AW-1:0] new_sp,
  output logic          err_o
);
  seq_state_t    state;
  logic [AW-1:0] pc_lat;
  logic [AW-1:0] sp_lat;
  logic [AW-1:0] target;
  logic [BW-1:0] vbyte;

  assign is_idle  = (state == S_IDLE);
  assign take_nmi = is_idle && insn_done && nmi_pend;
  assign take_irq = is_idle && insn_done && !nmi_pend && irq_req &&
                    ie1 && !ei_block && !cmd_en;

  assign push_hi     = (state == S_PUSH_H);
  assign push_lo     = (state == S_PUSH_L);
  assign ack_o       = (state == S_ACK);
  assign mem_rd_en   = (state == S_RD_LO) || (state == S_RD_HI);
  assign mem_rd_addr = table_ptr(ivec, vbyte, state == S_RD_HI);
  assign mem_wr_en   = push_hi || push_lo;
  assign mem_wr_addr = stack_slot(sp_lat, push_hi ? 2'd1 : 2'd2);
  assign mem_wr_data = push_hi ? pc_lat[AW-1:BW] : pc_lat[BW-1:0];
  assign done_o      = (state == S_FIN);
  assign new_pc      = target;
  assign new_sp      = stack_slot(sp_lat, 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      pc_lat    <= '0;
      sp_lat    <= '0;
      target    <= '0;
      vbyte     <= '0;
      entry_nmi <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      err_o <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (take_nmi) begin
            pc_lat    <= pc_in;
            sp_lat    <= sp_in;
            target    <= NMI_VEC;
            entry_nmi <= 1'b1;
            state     <= S_PUSH_H;
          end else if (take_irq) begin
            pc_lat    <= pc_in;
            sp_lat    <= sp_in;
            entry_nmi <= 1'b0;
            state     <= S_ACK;
          end
        end
        S_ACK: begin
          vbyte <= dev_data;
          case (mode)
            M_DEV: begin
              if (rst_ok(dev_data)) begin
                target <= rst_target(dev_data);
                state  <= S_PUSH_H;
              end else begin
                err_o <= 1'b1;
                state <= S_IDLE;
              end
            end
            M_FIX: begin
              target <= FIX_VEC;
              state  <= S_PUSH_H;
            end
            default: state <= S_RD_LO;
          endcase
        end
        S_RD_LO: begin
          target[BW-1:0] <= mem_rd_data;
          state          <= S_RD_HI;
        end
        S_RD_HI: begin
          target[AW-1:BW] <= mem_rd_data;
          state           <= S_PUSH_H;
        end
        S_PUSH_H: state <= S_PUSH_L;
        S_PUSH_L: state <= S_FIN;
        S_FIN:    state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irqv_pkg::*;
#(
  parameter logic [15:0] NMI_VEC = 16'h0066,
  parameter logic [15:0] FIX_VEC = 16'h0038
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nmi_in,
  input  logic          irq_req,
  input  logic          insn_done,
  input  logic          cmd_en,
  input  logic          cmd_dis,
  input  logic          cmd_retn,
  input  logic          cmd_mode_set,
  input  logic [1:0]    cmd_mode,
  input  logic          cmd_vec_set,
  input  logic [7:0]    cmd_vec,
  input  logic [15:0]   pc_in,
  input  logic [15:0]   sp_in,
  input  logic [7:0]    dev_data,
  output logic          ack_o,
  output logic          mem_rd_en,
  output logic [15:0]   mem_rd_addr,
  input  logic [7:0]    mem_rd_data,
  output logic          mem_wr_en,
  output logic [15:0]   mem_wr_addr,
  output logic [7:0]    mem_wr_data,
  output logic          done_o,
  output logic [15:0]   new_pc,
  output logic [15:0]   new_sp,
  output logic          err_o,
  output logic          busy_o,
  output logic          ie_o
);
  // named internal events, visible to the bound checker
  logic      nmi_pend;
  logic      take_nmi;
  logic      take_irq;
  logic      is_idle;
  logic      push_hi;
  logic      push_lo;
  logic      entry_nmi;
  logic      ie1;
  logic      ie2;
  logic      ei_block;
  irq_mode_t mode;
  logic [7:0] ivec;

  irqv_nmi_edge u_nmi (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .take(take_nmi), .pend(nmi_pend)
  );

  irqv_flags u_flags (
    .clk(clk), .rst_n(rst_n), .cmd_ok(is_idle),
    .cmd_en(cmd_en), .cmd_dis(cmd_dis), .cmd_retn(cmd_retn),
    .cmd_mode_set(cmd_mode_set), .cmd_mode(cmd_mode),
    .cmd_vec_set(cmd_vec_set), .cmd_vec(cmd_vec),
    .insn_done(insn_done), .take_nmi(take_nmi), .take_irq(take_irq),
    .ie1(ie1), .ie2(ie2), .ei_block(ei_block), .mode(mode), .ivec(ivec)
  );

  irqv_seq #(.NMI_VEC(NMI_VEC), .FIX_VEC(FIX_VEC)) u_seq (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .nmi_pend(nmi_pend),
    .irq_req(irq_req), .ie1(ie1), .ei_block(ei_block), .cmd_en(cmd_en),
    .mode(mode), .ivec(ivec), .dev_data(dev_data), .pc_in(pc_in),
    .sp_in(sp_in), .mem_rd_data(mem_rd_data),
    .take_nmi(take_nmi), .take_irq(take_irq), .is_idle(is_idle),
    .push_hi(push_hi), .push_lo(push_lo), .entry_nmi(entry_nmi),
    .ack_o(ack_o), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .done_o(done_o), .new_pc(new_pc),
    .new_sp(new_sp), .err_o(err_o)
  );

  assign busy_o = !is_idle;
  assign ie_o   = ie1;
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
  parameter logic [15:0] NMI_VEC = 16'h0066
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ack_o,
  input logic        ie_o,
  input logic        mem_wr_en,
  input logic        mem_rd_en,
  input logic [15:0] mem_rd_addr,
  input logic [7:0]  ivec,
  input logic        done_o,
  input logic        err_o,
  input logic        push_hi,
  input logic        push_lo,
  input logic        entry_nmi,
  input logic [15:0] new_pc,
  input logic        insn_done,
  input logic        is_idle,
  input logic        nmi_pend,
  input logic        ei_block
);
  // R5: an acknowledge only follows a cycle with the flag set
  a_r5_ack_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(ie_o));

  // R7: acceptance has cleared the flag by the acknowledge cycle
  a_r7_ack_clears_ie: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> !ie_o);

  // R7: acknowledge lasts one cycle
  a_r7_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);

  // R12: high byte push is followed by low byte push, then completion
  a_r12_push_order: assert property (@(posedge clk) disable iff (!rst_n)
    push_hi |=> push_lo);
  a_r12_push_done: assert property (@(posedge clk) disable iff (!rst_n)
    push_lo |=> done_o);

  // R10: an error pulse comes with no write and no completion
  a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!mem_wr_en && !done_o && !ie_o));

  // R2: a non-maskable entry completes at its fixed vector
  a_r2_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && entry_nmi) |-> (new_pc == NMI_VEC));

  // R6: the boundary right after an enable cannot yield an acknowledge
  a_r6_ei_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (is_idle && insn_done && ei_block && !nmi_pend) |=> !ack_o);

  // R11: table reads stay inside the page named by the base register
  a_r11_table_page: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (mem_rd_addr[15:8] == ivec));
endmodule

bind irq_vector_unit irqv_checker #(.NMI_VEC(NMI_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_o(ack_o), .ie_o(ie_o),
  .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
  .ivec(ivec), .done_o(done_o), .err_o(err_o), .push_hi(push_hi),
  .push_lo(push_lo), .entry_nmi(entry_nmi), .new_pc(new_pc),
  .insn_done(insn_done), .is_idle(is_idle), .nmi_pend(nmi_pend),
  .ei_block(ei_block)
);

// File: tb/irq_vector_unit_tb.sv
module irq_vector_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_in = 1'b0, irq_req = 1'b0, insn_done = 1'b0;
  logic        cmd_en = 1'b0, cmd_dis = 1'b0, cmd_retn = 1'b0;
  logic        cmd_mode_set = 1'b0, cmd_vec_set = 1'b0;
  logic [1:0]  cmd_mode = 2'd0;
  logic [7:0]  cmd_vec = 8'h00;
  logic [15:0] pc_in = 16'h1234, sp_in = 16'h8000;
  logic [7:0]  dev_data = 8'h00;
  logic        ack_o, mem_rd_en, mem_wr_en, done_o, err_o, busy_o, ie_o;
  logic [15:0] mem_rd_addr, mem_wr_addr, new_pc, new_sp;
  logic [7:0]  mem_rd_data, mem_wr_data;

  int checks = 0;
  int errors = 0;

  // event log filled by the monitor
  int          ack_cnt, done_cnt, err_cnt, wr_cnt;
  logic [15:0] got_pc, got_sp;
  logic [15:0] wa [0:3];
  logic [7:0]  wd [0:3];

  always #4 clk = ~clk;   // 125 MHz

  function automatic logic [7:0] tbl_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign mem_rd_data = tbl_byte(mem_rd_addr);

  irq_vector_unit u_dut (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .irq_req(irq_req),
    .insn_done(insn_done), .cmd_en(cmd_en), .cmd_dis(cmd_dis),
    .cmd_retn(cmd_retn), .cmd_mode_set(cmd_mode_set), .cmd_mode(cmd_mode),
    .cmd_vec_set(cmd_vec_set), .cmd_vec(cmd_vec), .pc_in(pc_in),
    .sp_in(sp_in), .dev_data(dev_data), .ack_o(ack_o),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .done_o(done_o),
    .new_pc(new_pc), .new_sp(new_sp), .err_o(err_o), .busy_o(busy_o),
    .ie_o(ie_o)
  );

  always @(negedge clk) begin
    if (ack_o) ack_cnt++;
    if (err_o) err_cnt++;
    if (done_o) begin
      done_cnt++;
      got_pc = new_pc;
      got_sp = new_sp;
    end
    if (mem_wr_en) begin
      if (wr_cnt < 4) begin
        wa[wr_cnt] = mem_wr_addr;
        wd[wr_cnt] = mem_wr_data;
      end
      wr_cnt++;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    ack_cnt = 0; done_cnt = 0; err_cnt = 0; wr_cnt = 0;
    got_pc = 16'hxxxx; got_sp = 16'hxxxx;
  endtask

  task automatic strobe_en();
    @(negedge clk) cmd_en = 1'b1;
    @(negedge clk) cmd_en = 1'b0;
  endtask

  task automatic strobe_dis();
    @(negedge clk) cmd_dis = 1'b1;
    @(negedge clk) cmd_dis = 1'b0;
  endtask

  task automatic strobe_retn();
    @(negedge clk) cmd_retn = 1'b1;
    @(negedge clk) cmd_retn = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk) begin cmd_mode_set = 1'b1; cmd_mode = m; end
    @(negedge clk) cmd_mode_set = 1'b0;
  endtask

  task automatic set_base(input logic [7:0] b);
    @(negedge clk) begin cmd_vec_set = 1'b1; cmd_vec = b; end
    @(negedge clk) cmd_vec_set = 1'b0;
  endtask

  // one instruction boundary, then let any entry sequence run out
  task automatic boundary();
    clear_log();
    @(negedge clk) insn_done = 1'b1;
    @(negedge clk) insn_done = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  // enable, then pass the one blocked boundary with no request
  task automatic arm();
    strobe_en();
    irq_req = 1'b0;
    boundary();
  endtask

  task automatic t_reset();
    chk(ie_o == 1'b0, "R1 ie", ie_o, 0);
    chk(!busy_o && !ack_o && !done_o && !err_o && !mem_rd_en && !mem_wr_en,
        "R1 idle outputs", {busy_o, ack_o, done_o, err_o, mem_rd_en, mem_wr_en}, 0);
  endtask

  task automatic t_disabled();
    irq_req = 1'b1; dev_data = 8'hFF;
    boundary();
    chk(ack_cnt == 0, "R5 no ack while disabled", ack_cnt, 0);
    strobe_en(); boundary(); strobe_dis();
    boundary();
    chk(ack_cnt == 0 && !ie_o, "R5 disable command", ack_cnt, 0);
    irq_req = 1'b0;
  endtask

  task automatic t_ei_delay();
    set_mode(2'd1);
    dev_data = 8'hC7;
    strobe_en();
    irq_req = 1'b1;
    boundary();
    chk(ack_cnt == 0, "R6 first boundary blocked", ack_cnt, 0);
    chk(ie_o == 1'b1, "R6 flag still set", ie_o, 1);
    boundary();
    chk(ack_cnt == 1, "R7 one ack cycle", ack_cnt, 1);
    chk(ie_o == 1'b0, "R7 flag cleared", ie_o, 0);
    chk(done_cnt == 1 && got_pc == 16'h0038, "R8 fixed vector", got_pc, 16'h0038);
    irq_req = 1'b0;
  endtask

  task automatic t_push();
    pc_in = 16'hBEEF; sp_in = 16'h4000;
    arm();
    irq_req = 1'b1;
    boundary();
    irq_req = 1'b0;
    chk(wr_cnt == 2, "R12 two writes", wr_cnt, 2);
    chk(wa[0] == 16'h3FFF && wd[0] == 8'hBE, "R12 high byte first",
        {wa[0], wd[0]}, {16'h3FFF, 8'hBE});
    chk(wa[1] == 16'h3FFE && wd[1] == 8'hEF, "R12 low byte second",
        {wa[1], wd[1]}, {16'h3FFE, 8'hEF});
    chk(got_sp == 16'h3FFE, "R12 new sp", got_sp, 16'h3FFE);
    pc_in = 16'h1234; sp_in = 16'h8000;
  endtask

  task automatic t_mode0(input logic [7:0] op);
    logic [15:0] exp;
    exp = {10'd0, op[5:3], 3'd0};
    set_mode(2'd0);
    dev_data = op;
    arm();
    irq_req = 1'b1;
    boundary();
    irq_req = 1'b0;
    chk(done_cnt == 1 && got_pc == exp, "R9 restart vector", got_pc, exp);
  endtask

  task automatic t_mode0_bad();
    set_mode(2'd0);
    dev_data = 8'h3E;
    arm();
    irq_req = 1'b1;
    boundary();
    irq_req = 1'b0;
    chk(err_cnt == 1, "R10 error pulse", err_cnt, 1);
    chk(wr_cnt == 0 && done_cnt == 0, "R10 no push no done",
        {wr_cnt[15:0], done_cnt[15:0]}, 0);
    chk(ie_o == 1'b0, "R10 flag cleared", ie_o, 0);
  endtask

  task automatic t_mode2();
    logic [15:0] ptr;
    logic [15:0] exp;
    set_mode(2'd2);
    set_base(8'h40);
    dev_data = 8'h15;
    ptr = 16'h4014;
    exp = {tbl_byte(ptr + 16'd1), tbl_byte(ptr)};
    arm();
    irq_req = 1'b1;
    boundary();
    irq_req = 1'b0;
    chk(done_cnt == 1 && got_pc == exp, "R11 table handler", got_pc, exp);
  endtask

  task automatic t_mode3_ignored();
    set_mode(2'd1);
    set_mode(2'd3);
    dev_data = 8'hEF;
    arm();
    irq_req = 1'b1;
    boundary();
    irq_req = 1'b0;
    chk(done_cnt == 1 && got_pc == 16'h0038, "R13 mode 3 ignored", got_pc, 16'h0038);
  endtask

  task automatic t_nmi();
    arm();
    @(negedge clk) nmi_in = 1'b1;
    boundary();
    chk(done_cnt == 1 && got_pc == 16'h0066, "R2 nmi vector", got_pc, 16'h0066);
    chk(ack_cnt == 0, "R2 no ack on nmi", ack_cnt, 0);
    chk(ie_o == 1'b0, "R3 flag cleared on nmi", ie_o, 0);
    boundary();
    chk(done_cnt == 0, "R2 held level no re-entry", done_cnt, 0);
    strobe_retn();
    chk(ie_o == 1'b1, "R3 flag restored", ie_o, 1);
    @(negedge clk) nmi_in = 1'b0;
    // saved flag clear: restore keeps it clear
    strobe_dis();
    @(negedge clk) nmi_in = 1'b1;
    boundary();
    @(negedge clk) nmi_in = 1'b0;
    strobe_retn();
    chk(done_cnt == 1 && ie_o == 1'b0, "R3 restore of clear flag", ie_o, 0);
  endtask

  task automatic t_prio();
    set_mode(2'd1);
    arm();
    irq_req = 1'b1;
    @(negedge clk) nmi_in = 1'b1;
    boundary();
    chk(got_pc == 16'h0066 && ack_cnt == 0, "R4 nmi wins",
        {got_pc, ack_cnt[15:0]}, {16'h0066, 16'h0});
    irq_req = 1'b0;
    @(negedge clk) nmi_in = 1'b0;
    strobe_retn();
  endtask

  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<20000", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    clear_log();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_ei_delay();
    t_push();
    t_mode0(8'hC7);
    t_mode0(8'hEF);
    t_mode0(8'hFF);
    t_mode0_bad();
    t_mode2();
    t_mode3_ignored();
    t_nmi();
    t_prio();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule